// File: doc/BRIEF.md
# SDRAM Access Request Pulse Shaper

This block sits between a simple processor bus and the request port of an SDRAM controller. The processor may hold its chip select for as many cycles as it likes. The block turns each such access into one request of the right length for the controller:

- A write becomes a single-clock request.
- A read keeps its request raised until the controller reports that data is present.

The block then shows a ready flag to the processor and holds the read data for it. It issues no further request until the chip select has been released.

Only addresses inside the SDRAM window start an access. The window is given by the top address bits, and it is the region that internal RAM used to occupy. The rest of the map, such as the internal ROM, is served elsewhere and is ignored here.

The control machine has exactly two states:

- **IDLE**: no access is open. A chip select with an in-window address captures the operation, address and write data, and takes the transition *start* to ACTIVE.
- **ACTIVE**: this state carries a completion flag. While the flag is clear, the request is driven. The flag is set on the first cycle for a write, or on the cycle the controller's data-valid is sampled for a read.
  - Once the flag is set, ready is shown.
  - The transition *release* returns to IDLE on the first clock at which the chip select is sampled low.

Top module: `sdram_req_shaper`

## Requirements
- R1: During and right after reset, mem_req, cpu_ready and cpu_rdata are all 0.
- R2: For a write (cpu_we=1), mem_req is high for exactly one clock, beginning the cycle after the clock that samples cpu_cs. In that cycle mem_we=1 and mem_addr/mem_wdata equal the processor's address and data.
- R3: For a read (cpu_we=0), mem_req rises the cycle after cpu_cs is sampled, with mem_we=0. It stays high up to and including the cycle in which mem_rvalid is high, and it is low in the cycle after.
- R4: mem_rdata is captured on the clock that samples mem_rvalid, is shown on cpu_rdata from the next cycle, and stays unchanged through later writes until another read completes.
- R5: cpu_ready is high from the cycle after completion until the cycle after cpu_cs is sampled low. While cpu_cs stays high after completion, no further request is issued.
- R6: A chip select whose address top bit (cpu_addr[ADDR_W-1]) is 0 lies outside the SDRAM window. It causes no request and never raises cpu_ready.
- R7: mem_addr, mem_we and mem_wdata stay unchanged for every cycle that mem_req is high.
- R8: A write whose chip select is high for only one sampled clock still issues its single request, and then shows cpu_ready for one cycle.
- R9: After a release, a new in-window chip select starts a fresh access, so back-to-back accesses each give exactly one request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_cs | input | 1 | Processor chip select |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Processor address |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_rdata | output | DATA_W | Held read data |
| cpu_ready | output | 1 | Access finished |
| mem_req | output | 1 | Request to SDRAM controller |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Request address |
| mem_wdata | output | DATA_W | Request write data |
| mem_rdata | input | DATA_W | Controller read data |
| mem_rvalid | input | 1 | Controller read data present |

## Verification
The hardest case to reach is a processor that keeps its chip select high long after completion. This is where a faulty machine would issue a second request. The driver holds the select for a chosen number of extra cycles, and the monitor flags any request that the queue does not expect. The other hard cases are a select that falls before the write request has even gone out, and reads whose controller latency varies from zero to several cycles. A bench-side controller model creates these by delaying mem_rvalid by a chosen number of cycles.

// File: rtl/sdram_req_shaper_pkg.sv
package sdram_req_shaper_pkg;
    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_ACTIVE = 1'b1
    } shaper_state_t;
endpackage

// File: rtl/sdram_req_window.sv
module sdram_req_window #(
    parameter int ADDR_W   = 16,
    parameter int WIN_W    = 1,
    parameter int WIN_BASE = 1
) (
    input  logic              cpu_cs,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              access_start
);
    localparam logic [WIN_W-1:0] BASE = WIN_BASE[WIN_W-1:0];

    logic in_window;

    always_comb begin
        in_window    = (cpu_addr[ADDR_W-1 -: WIN_W] == BASE);
        access_start = cpu_cs && in_window;
    end
endmodule

// File: rtl/sdram_req_fsm.sv
module sdram_req_fsm
    import sdram_req_shaper_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic access_start,
    input  logic op_write,
    input  logic cpu_cs,
    input  logic mem_rvalid,
    output logic mem_req,
    output logic cpu_ready,
    output logic capture_en,
    output logic rdata_load
);
    shaper_state_t state_q, state_d;
    logic          done_q, done_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= done_d;
        end
    end

    // transitions: start and release
    always_comb begin
        state_d = state_q;
        done_d  = done_q;
        unique case (state_q)
            ST_IDLE: begin
                if (access_start) begin
                    state_d = ST_ACTIVE;
                    done_d  = 1'b0;
                end
            end
            ST_ACTIVE: begin
                if (!done_q) begin
                    if (op_write || mem_rvalid) done_d = 1'b1;
                end else if (!cpu_cs) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        capture_en = 1'b0;
        mem_req    = 1'b0;
        cpu_ready  = 1'b0;
        rdata_load = 1'b0;
        unique case (state_q)
            ST_IDLE:   capture_en = access_start;
            ST_ACTIVE: begin
                mem_req    = !done_q;
                cpu_ready  = done_q;
                rdata_load = !done_q && !op_write && mem_rvalid;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sdram_req_capture.sv
module sdram_req_capture #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_en,
    input  logic              rdata_load,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              op_we,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_wdata,
    output logic [DATA_W-1:0] rd_hold
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_we    <= 1'b0;
            op_addr  <= '0;
            op_wdata <= '0;
        end else if (capture_en) begin
            op_we    <= cpu_we;
            op_addr  <= cpu_addr;
            op_wdata <= cpu_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)          rd_hold <= '0;
        else if (rdata_load) rd_hold <= mem_rdata;
    end
endmodule

// File: rtl/sdram_req_shaper.sv
module sdram_req_shaper #(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter int WIN_W    = 1,
    parameter int WIN_BASE = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_cs,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_rvalid
);
    logic access_start, capture_en, rdata_load;

    sdram_req_window #(
        .ADDR_W(ADDR_W), .WIN_W(WIN_W), .WIN_BASE(WIN_BASE)
    ) u_window (
        .cpu_cs(cpu_cs), .cpu_addr(cpu_addr), .access_start(access_start)
    );

    sdram_req_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .access_start(access_start),
        .op_write(mem_we), .cpu_cs(cpu_cs), .mem_rvalid(mem_rvalid),
        .mem_req(mem_req), .cpu_ready(cpu_ready),
        .capture_en(capture_en), .rdata_load(rdata_load)
    );

    sdram_req_capture #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_capture (
        .clk(clk), .rst_n(rst_n), .capture_en(capture_en),
        .rdata_load(rdata_load), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .mem_rdata(mem_rdata), .op_we(mem_we),
        .op_addr(mem_addr), .op_wdata(mem_wdata), .rd_hold(cpu_rdata)
    );
endmodule

// File: rtl/sdram_req_shaper_chk.sv
module sdram_req_shaper_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_cs,
    input logic              cpu_ready,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic [DATA_W-1:0] mem_rdata,
    input logic              mem_rvalid,
    input logic [DATA_W-1:0] cpu_rdata
);
    assert_write_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |=> !mem_req);

    assert_read_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && !mem_rvalid) |=> mem_req);

    assert_read_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_rvalid) |=> !mem_req);

    assert_rdata_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_rvalid) |=> (cpu_rdata == $past(mem_rdata)));

    assert_no_rerequest_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && cpu_cs) |=> (!mem_req && cpu_ready));

    assert_req_ready_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && cpu_ready));

    assert_stable_fields_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && $past(mem_req)) |-> ($stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
endmodule

bind sdram_req_shaper sdram_req_shaper_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_cs(cpu_cs), .cpu_ready(cpu_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid),
    .cpu_rdata(cpu_rdata)
);

// File: tb/test_sdram_req_shaper.sv
module test_sdram_req_shaper;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int WATCHDOG = 20000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cpu_cs = 1'b0, cpu_we = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [DATA_W-1:0] cpu_wdata = '0;
    logic [DATA_W-1:0] cpu_rdata;
    logic              cpu_ready, mem_req, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rdata = '0;
    logic              mem_rvalid = 1'b0;

    int checks = 0, errors = 0, cycles = 0;
    int rd_lat = 0, lat_cnt = 0;
    bit finished = 1'b0;
    logic prev_req = 1'b0, prev_we = 1'b0, prev_rvalid = 1'b0;
    logic [ADDR_W-1:0] prev_addr = '0;
    logic [DATA_W-1:0] prev_wdata = '0;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } req_item_t;
    req_item_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_req_shaper #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_sdram_req_shaper (
        .clk(clk), .rst_n(rst_n), .cpu_cs(cpu_cs), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_ready(cpu_ready), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_rvalid(mem_rvalid)
    );

    function automatic logic [DATA_W-1:0] model_data(input logic [ADDR_W-1:0] a);
        return a[DATA_W-1:0] ^ 8'hA5;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor and controller model, both at negedge, monitor first
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_req && !prev_req) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5/R6 unexpected request", {15'd0, mem_we, mem_addr}, 0);
                end else begin
                    req_item_t e;
                    e = exp_q.pop_front();
                    check(mem_we == e.we, "R2/R3 request kind", mem_we, e.we);
                    check(mem_addr == e.addr, "R2/R3 request address", mem_addr, e.addr);
                    if (e.we) check(mem_wdata == e.data, "R2 write data", mem_wdata, e.data);
                end
            end
            if (prev_req && prev_we)
                check(!mem_req, "R2 write pulse length", mem_req, 0);
            if (prev_req && !prev_we && !prev_rvalid)
                check(mem_req, "R3 read request held", mem_req, 1);
            if (prev_req && !prev_we && prev_rvalid)
                check(!mem_req, "R3 read request dropped", mem_req, 0);
            if (prev_req && mem_req)
                check(mem_addr == prev_addr && mem_wdata == prev_wdata && mem_we == prev_we,
                      "R7 fields stable", mem_addr, prev_addr);
        end
        prev_req    = mem_req;
        prev_we     = mem_we;
        prev_addr   = mem_addr;
        prev_wdata  = mem_wdata;
        // controller model
        if (mem_req && !mem_we && !mem_rvalid) begin
            if (lat_cnt >= rd_lat) begin
                mem_rvalid = 1'b1;
                mem_rdata  = model_data(mem_addr);
            end else begin
                lat_cnt++;
            end
        end else begin
            mem_rvalid = 1'b0;
            mem_rdata  = 8'hEE;
            lat_cnt    = 0;
        end
        prev_rvalid = mem_rvalid;
    end

    // processor-side driver: one access, chip select held extra cycles after ready
    task automatic access(input logic we, input logic [ADDR_W-1:0] a,
                          input logic [DATA_W-1:0] d, input int hold, input int lat);
        int waited;
        @(negedge clk);
        rd_lat    = lat;
        cpu_cs    = 1'b1;
        cpu_we    = we;
        cpu_addr  = a;
        cpu_wdata = d;
        exp_q.push_back('{we: we, addr: a, data: d});
        waited = 0;
        do begin
            @(negedge clk);
            waited++;
        end while (!cpu_ready && waited < 50);
        check(cpu_ready, "R5 ready raised", cpu_ready, 1);
        if (!we) check(cpu_rdata == model_data(a), "R4 read data", cpu_rdata, model_data(a));
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            check(cpu_ready, "R5 ready held while select high", cpu_ready, 1);
        end
        cpu_cs = 1'b0;
        @(negedge clk);
        check(!cpu_ready, "R5 ready dropped after release", cpu_ready, 0);
    endtask

    initial begin
        logic [DATA_W-1:0] saved;
        repeat (3) @(negedge clk);
        check(!mem_req && !cpu_ready && cpu_rdata == '0, "R1 reset state",
              {mem_req, cpu_ready, cpu_rdata}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!mem_req && !cpu_ready && cpu_rdata == '0, "R1 after reset",
              {mem_req, cpu_ready, cpu_rdata}, 0);

        access(1'b1, 16'h8010, 8'h3C, 0, 0);   // R2 short write
        access(1'b1, 16'h9ABC, 8'h5A, 6, 0);   // R2, R5 long hold
        access(1'b0, 16'h8123, 8'h00, 0, 0);   // R3 zero latency
        access(1'b0, 16'hC0F1, 8'h00, 4, 3);   // R3, R4 latency 3
        saved = cpu_rdata;
        access(1'b1, 16'hA000, 8'h77, 2, 0);
        check(cpu_rdata == saved, "R4 read data held over write", cpu_rdata, saved);
        access(1'b0, 16'hFFFF, 8'h00, 1, 7);   // R3 latency 7

        // R6: out-of-window select
        @(negedge clk);
        cpu_cs = 1'b1; cpu_we = 1'b0; cpu_addr = 16'h1234;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check(!cpu_ready && !mem_req, "R6 outside window ignored", {cpu_ready, mem_req}, 0);
        end
        cpu_we = 1'b1;
        @(negedge clk);
        check(!cpu_ready && !mem_req, "R6 outside window write ignored", {cpu_ready, mem_req}, 0);
        cpu_cs = 1'b0;

        // R8: single-cycle select for a write
        @(negedge clk);
        cpu_cs = 1'b1; cpu_we = 1'b1; cpu_addr = 16'hB00B; cpu_wdata = 8'hC3;
        exp_q.push_back('{we: 1'b1, addr: 16'hB00B, data: 8'hC3});
        @(negedge clk);
        cpu_cs = 1'b0;
        check(mem_req, "R8 request issued after early drop", mem_req, 1);
        @(negedge clk);
        check(cpu_ready && !mem_req, "R8 ready shown once", {cpu_ready, mem_req}, 2);
        @(negedge clk);
        check(!cpu_ready, "R8 ready gone", cpu_ready, 0);

        // R9: back-to-back accesses
        access(1'b0, 16'h8800, 8'h00, 0, 1);
        access(1'b1, 16'h8801, 8'h11, 0, 0);
        access(1'b0, 16'h8802, 8'h00, 0, 2);

        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R9 all expected requests seen", exp_q.size(), 0);

        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule